// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous binary counter of parameterised width (four bits by default) meant to be chained into wider counters on a shared clock. On each rising clock edge it either clears, loads a parallel word, counts up by one, or holds. Counting needs two enables to be high: a parallel enable, which affects only this stage, and a trickle enable, which also gates the carry output. The carry output is high when the count is all ones and the trickle enable is high. It drives the trickle enable of the next stage.

A parameter selects how the active-low clear behaves. In the asynchronous form the clear zeroes the count at once, without a clock edge. In the synchronous form it zeroes the count on the next rising edge, and it wins over load and count. With the synchronous form, a decode of the outputs fed back into the clear shortens the count modulus below the full binary range.

Top module: `casc_bin_counter`

## Requirements
- R1: With ASYNC_CLR=1, a low on clr_n forces q to zero at once, without a clock edge, and keeps it at zero across clock edges whatever load_n, en_par, en_trk and din are.
- R2: With ASYNC_CLR=0, a low on clr_n leaves q unchanged until the next rising edge and sets q to zero on that edge, taking priority over load and both enables.
- R3: With clr_n high and load_n low, q takes the value of din on the next rising edge, whatever en_par and en_trk are.
- R4: With clr_n high, load_n high, en_par high and en_trk high, q increases by one on each rising edge.
- R5: With clr_n high, load_n high and either en_par or en_trk low, q holds its value.
- R6: Incrementing from the all-ones value gives zero.
- R7: tc is high exactly when en_trk is high and q is all ones. It follows en_trk combinationally, with no clock edge.
- R8: Three stages sharing one clock, with en_par of every stage driven by a common enable and en_trk of each later stage driven by tc of the stage before, count as one 12-bit counter through all 4096 values. The last stage's tc is high only at count 4095.
- R9: A synchronous-clear stage whose clr_n is driven low by a decode of q equal to 9 counts 0 through 9 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low parallel load |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates tc |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count carry |

## Verification
Load, count, hold and synchronous clear act on the first rising edge after the control levels are applied. The driver sets the controls on the falling edge and queues the value due after the following rising edge. The monitor compares that value one time unit after the rising edge. The asynchronous clear and the combinational tc have zero latency, so they are checked in the middle of a clock phase, with no edge in between. For the synchronous clear, a mid-cycle check also shows that q has not yet changed before its edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    CNT_OP_CLEAR = 2'd0,
    CNT_OP_LOAD  = 2'd1,
    CNT_OP_STEP  = 2'd2,
    CNT_OP_KEEP  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output cnt_op_e op
);
  // priority: clear, load, count, hold
  always_comb begin
    if (!clr_n)                op = CNT_OP_CLEAR;
    else if (!load_n)          op = CNT_OP_LOAD;
    else if (en_par && en_trk) op = CNT_OP_STEP;
    else                       op = CNT_OP_KEEP;
  end
endmodule

// File: rtl/cnt_next_val.sv
module cnt_next_val
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      CNT_OP_CLEAR: nxt = '0;
      CNT_OP_LOAD:  nxt = din;
      CNT_OP_STEP:  nxt = cur + ONE;
      default:      nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cur
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cur <= '0;
        else        cur <= nxt;
      end
    end else begin : g_sync
      // clear already folded into nxt by the op selector
      always_ff @(posedge clk) begin
        cur <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_trk,
  output logic             tc
);
  always_comb begin
    tc = en_trk & (&cur);
  end
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] cur;

  cnt_op_sel u_sel (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .op     (op)
  );

  cnt_next_val #(.WIDTH(WIDTH)) u_nxt (
    .op  (op),
    .cur (cur),
    .din (din),
    .nxt (nxt)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .cur   (cur)
  );

  cnt_carry_gen #(.WIDTH(WIDTH)) u_tc (
    .cur    (cur),
    .en_trk (en_trk),
    .tc     (tc)
  );

  assign q = cur;
endmodule

// File: rtl/casc_bin_counter_chk.sv
module casc_bin_counter_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             tc
);
  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din)); // R3

  AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> q == WIDTH'($past(q) + 1'b1)); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q)); // R5

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && (&q)) |=> q == '0); // R6

  AST_TC_NEEDS_MAX: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (&q)); // R7

  AST_TC_NEEDS_TRK: assert property (@(posedge clk) disable iff (!clr_n)
    !en_trk |-> !tc); // R7

  generate
    if (ASYNC_CLR) begin : g_async_chk
      AST_ASYNC_CLR_ZERO: assert property (@(posedge clk)
        !clr_n |-> q == '0); // R1
    end else begin : g_sync_chk
      AST_SYNC_CLR_ZERO: assert property (@(posedge clk)
        !clr_n |=> q == '0); // R2
    end
  endgenerate
endmodule

bind casc_bin_counter casc_bin_counter_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) chk_i (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_par (en_par),
  .en_trk (en_trk),
  .din    (din),
  .q      (q),
  .tc     (tc)
);

// File: tb/casc_bin_counter_tb_top.sv
module casc_bin_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;

  typedef struct {
    int          unit;
    logic [11:0] val;
    logic        tc;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];

  // unit 0: asynchronous-clear stage
  logic a_clr, a_ld, a_ep, a_et;
  logic [3:0] a_d, a_q;
  logic a_tc;
  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut_i (
    .clk(clk), .clr_n(a_clr), .load_n(a_ld), .en_par(a_ep), .en_trk(a_et),
    .din(a_d), .q(a_q), .tc(a_tc));

  // unit 1: synchronous-clear stage
  logic s_clr, s_ld, s_ep, s_et;
  logic [3:0] s_d, s_q;
  logic s_tc;
  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_s (
    .clk(clk), .clr_n(s_clr), .load_n(s_ld), .en_par(s_ep), .en_trk(s_et),
    .din(s_d), .q(s_q), .tc(s_tc));

  // unit 2: three-stage chain
  logic c_clr, cen;
  logic [3:0] c_q0, c_q1, c_q2;
  logic c_tc0, c_tc1, c_tc2;
  casc_bin_counter dut_c0 (.clk(clk), .clr_n(c_clr), .load_n(1'b1), .en_par(cen),
    .en_trk(cen), .din(4'h0), .q(c_q0), .tc(c_tc0));
  casc_bin_counter dut_c1 (.clk(clk), .clr_n(c_clr), .load_n(1'b1), .en_par(cen),
    .en_trk(c_tc0), .din(4'h0), .q(c_q1), .tc(c_tc1));
  casc_bin_counter dut_c2 (.clk(clk), .clr_n(c_clr), .load_n(1'b1), .en_par(cen),
    .en_trk(c_tc1), .din(4'h0), .q(c_q2), .tc(c_tc2));

  // unit 3: modulus-10 stage via decode into synchronous clear
  logic m_rst, m_clr;
  logic [3:0] m_q;
  logic m_tc;
  assign m_clr = m_rst & (m_q != 4'd9);
  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_m (
    .clk(clk), .clr_n(m_clr), .load_n(1'b1), .en_par(1'b1), .en_trk(1'b1),
    .din(4'h0), .q(m_q), .tc(m_tc));

  task automatic push(input int u, input int v, input logic t, input string tag);
    exp_t e;
    e.unit = u; e.val = 12'(v); e.tc = t; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic a_step(input logic ld, input logic ep, input logic et, input logic [3:0] d,
                        input int ev, input logic et_exp, input string tag);
    @(negedge clk);
    a_clr = 1'b1; a_ld = ld; a_ep = ep; a_et = et; a_d = d;
    push(0, ev, et_exp, tag);
  endtask

  task automatic s_step(input logic cl, input logic ld, input logic ep, input logic et,
                        input logic [3:0] d, input int ev, input logic et_exp, input string tag);
    @(negedge clk);
    s_clr = cl; s_ld = ld; s_ep = ep; s_et = et; s_d = d;
    push(1, ev, et_exp, tag);
  endtask

  // monitor: after each rising edge, pop everything due and compare
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [11:0] av;
      logic at;
      e = sb_q.pop_front();
      case (e.unit)
        0:       begin av = {8'h0, a_q}; at = a_tc; end
        1:       begin av = {8'h0, s_q}; at = s_tc; end
        2:       begin av = {c_q2, c_q1, c_q0}; at = c_tc2; end
        default: begin av = {8'h0, m_q}; at = m_tc; end
      endcase
      checks++;
      if (av !== e.val || at !== e.tc) begin
        errors++;
        $display("FAIL %s: actual q=%0h tc=%0b expected q=%0h tc=%0b",
                 e.tag, av, at, e.val, e.tc);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a_clr = 1'b0; a_ld = 1'b1; a_ep = 1'b0; a_et = 1'b0; a_d = 4'h0;
    s_clr = 1'b0; s_ld = 1'b1; s_ep = 1'b0; s_et = 1'b0; s_d = 4'h0;
    c_clr = 1'b0; cen = 1'b0;
    m_rst = 1'b0;

    // reset state of every unit
    @(negedge clk);
    push(0, 0, 1'b0, "R1 reset");
    push(1, 0, 1'b0, "R2 reset");
    push(2, 0, 1'b0, "R8 reset");
    push(3, 0, 1'b0, "R9 reset");

    // asynchronous-clear stage
    a_step(1'b0, 1'b0, 1'b0, 4'hA, 4'hA, 1'b0, "R3 load enables low");
    a_step(1'b0, 1'b1, 1'b1, 4'h5, 4'h5, 1'b0, "R3 load beats enables");
    a_step(1'b1, 1'b1, 1'b1, 4'h0, 4'h6, 1'b0, "R4 count");
    a_step(1'b1, 1'b1, 1'b1, 4'h0, 4'h7, 1'b0, "R4 count");
    a_step(1'b1, 1'b0, 1'b1, 4'h0, 4'h7, 1'b0, "R5 hold en_par low");
    a_step(1'b1, 1'b1, 1'b0, 4'h0, 4'h7, 1'b0, "R5 hold en_trk low");
    a_step(1'b0, 1'b0, 1'b0, 4'hE, 4'hE, 1'b0, "R3 load E");
    a_step(1'b1, 1'b1, 1'b1, 4'h0, 4'hF, 1'b1, "R7 tc at max");
    @(negedge clk);
    a_ep = 1'b0; a_et = 1'b0;
    #1 chk({11'h0, a_tc}, 12'h0, "R7 tc drops with en_trk");
    a_et = 1'b1;
    #1 chk({11'h0, a_tc}, 12'h1, "R7 tc rises with en_trk");
    a_step(1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 1'b0, "R7 tc gated at max");
    a_step(1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0, "R6 wrap");
    a_step(1'b0, 1'b0, 1'b0, 4'h9, 4'h9, 1'b0, "R3 load 9");
    @(negedge clk);
    #2 a_clr = 1'b0; a_ld = 1'b0; a_d = 4'h5; a_ep = 1'b1; a_et = 1'b1;
    #1 chk({8'h0, a_q}, 12'h0, "R1 immediate clear");
    push(0, 0, 1'b0, "R1 clear beats load");
    a_step(1'b1, 1'b1, 1'b1, 4'h0, 4'h1, 1'b0, "R4 count after clear");

    // synchronous-clear stage
    s_step(1'b1, 1'b0, 1'b0, 1'b0, 4'h3, 4'h3, 1'b0, "R3 load 3");
    s_step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h4, 1'b0, "R4 count");
    s_step(1'b0, 1'b0, 1'b1, 1'b1, 4'hA, 4'h0, 1'b0, "R2 clear beats load");
    s_step(1'b1, 1'b0, 1'b0, 1'b0, 4'h6, 4'h6, 1'b0, "R3 load 6");
    @(negedge clk);
    s_clr = 1'b0; s_ld = 1'b1;
    #1 chk({8'h0, s_q}, 12'h6, "R2 waits for edge");
    push(1, 0, 1'b0, "R2 clear on edge");
    s_step(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1, "R7 tc after load F");
    s_step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0, "R6 wrap sync");

    // modulus-10 stage
    @(negedge clk);
    m_rst = 1'b1;
    push(3, 1, 1'b0, "R9 mod10");
    for (int k = 2; k <= 25; k++) begin
      @(negedge clk);
      push(3, k % 10, 1'b0, "R9 mod10");
    end

    // three-stage chain over the full range
    for (int k = 1; k <= 4097; k++) begin
      @(negedge clk);
      c_clr = 1'b1; cen = 1'b1;
      push(2, k % 4096, (k % 4096) == 4095, "R8 chain");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule